// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable memory with a fully registered, pipelined bus on which reads and writes may follow one another on every clock in any mix, with no idle cycle when the direction changes. Address, command and byte enables are captured on a clock edge. The matching data phase comes two enabled edges later. For a read, that is when the word is presented on the output together with an output-enable flag. For a write, that is when the write data is sampled. Because both directions use the same delay, a write can sit directly behind a read and the data bus stays busy every cycle.

A new access is loaded when the advance input is low. The command is a read, a write, or a deselect when any of the three chip enables is inactive. With advance high, the block reuses the last command and steps a 2-bit burst counter through the low two address bits. The order is either a wrap-around sequence or an XOR sequence, chosen by a mode pin. An active-low clock enable freezes the entire pipeline. A read that hits a write still waiting for its data gets the new bytes forwarded to it, lane by lane. The shared data bus is modelled as separate input and output ports plus the enable flag.

Top module: `sram_nowait`

## Requirements
- R1: While rstN is low, dataOut is all zeros and dataOutEn is 0.
- R2: When a read is loaded (advance=0, rwN=1, chip selected), dataOutEn is 1 after the second following enabled edge, and dataOut then holds the word at that address, including all writes loaded earlier.
- R3: byteWeN is active low per lane. Bit i guards data bits [9i+8:9i]. On a write, only lanes whose bit is 0 are updated, and a write with all bits 1 changes nothing.
- R4: An access loaded while chipEn1N=1, chipEn2=0 or chipEn3N=1 is a deselect. It writes nothing and leaves dataOutEn at 0 in its data phase.
- R5: With advance=1, the previous command continues at the next burst address, whatever rwN and the chip enables are. Advancing after a deselect stays a deselect.
- R6: With burstMode=0, the low two address bits of burst beat n are (start + n) mod 4. The upper bits keep the loaded value.
- R7: With burstMode=1, the low two address bits of burst beat n are start XOR n.
- R8: An edge with clkEnN=1 ignores all inputs and leaves dataOut, dataOutEn and all pipeline state unchanged.
- R9: Reads and writes may be loaded on consecutive enabled edges in any order without idle cycles. A read loaded one edge after a write to the same address returns that write's bytes merged over the old word.
- R10: The data phase of a write leaves dataOutEn at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEnN | input | 1 | Clock enable, active low; high stalls the pipeline |
| advance | input | 1 | Low loads a new access, high steps the burst |
| rwN | input | 1 | Low write, high read (sampled on load) |
| chipEn1N | input | 1 | Chip enable, active low |
| chipEn2 | input | 1 | Chip enable, active high |
| chipEn3N | input | 1 | Chip enable, active low |
| burstMode | input | 1 | 0 wrap-around burst order, 1 XOR burst order |
| byteWeN | input | BYTES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| dataIn | input | BYTES*BYTE_W | Write data, sampled in the write data phase |
| dataOut | output | BYTES*BYTE_W | Registered read data |
| dataOutEn | output | 1 | High during the data phase of a selected read |

## Verification
The bench builds the block with ADDR_W=4, so the array has only 16 words, and keeps four 9-bit lanes. With so few words, the random traffic keeps hitting the same addresses. That produces many read-after-write forwarding hits, partial-lane merges and burst wraps across all four positions of a quad. It also lets every word be preloaded and checked against a model. Stalls are inserted between data phases and inside bursts, so the two-edge delay is exercised with enabled edges that are not consecutive.

// File: rtl/sram_nowait_pkg.sv
package sram_nowait_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pipeEn;   // enabled edge
    logic s2Write;  // data phase of a write
    logic s2Read;   // data phase of a read
    logic fwdHit;   // read in stage 1 matches write in stage 2
  } strobe_t;

endpackage

// File: rtl/sram_nowait_ctrl.sv
module sram_nowait_ctrl
  import sram_nowait_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              advance,
  input  logic              rwN,
  input  logic              chipEn1N,
  input  logic              chipEn2,
  input  logic              chipEn3N,
  input  logic              burstMode,
  input  logic [BYTES-1:0]  byteWeN,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] s1Addr,
  output logic [ADDR_W-1:0] s2Addr,
  output logic [BYTES-1:0]  s2ByteWe
);

  localparam int CNT_W = 2;

  logic              selected;
  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  burstCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic [CNT_W-1:0]  burstLow;
  cmd_t              lastCmd;
  cmd_t              capCmd;
  logic [ADDR_W-1:0] capAddr;
  cmd_t              s1Cmd;
  cmd_t              s2Cmd;
  logic [BYTES-1:0]  s1ByteWe;

  assign selected = !chipEn1N && chipEn2 && !chipEn3N;

  // address and command captured on this edge
  always_comb begin
    nextCnt  = burstCnt + CNT_W'(1);
    burstLow = burstMode ? (baseAddr[CNT_W-1:0] ^ nextCnt)
                         : (baseAddr[CNT_W-1:0] + nextCnt);
    if (!advance) begin
      capAddr = addr;
      if (!selected)  capCmd = CMD_IDLE;
      else if (rwN)   capCmd = CMD_READ;
      else            capCmd = CMD_WRITE;
    end else begin
      capAddr = {baseAddr[ADDR_W-1:CNT_W], burstLow};
      capCmd  = lastCmd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      burstCnt <= '0;
      lastCmd  <= CMD_IDLE;
      s1Cmd    <= CMD_IDLE;
      s1Addr   <= '0;
      s1ByteWe <= '0;
      s2Cmd    <= CMD_IDLE;
      s2Addr   <= '0;
      s2ByteWe <= '0;
    end else if (!clkEnN) begin
      if (!advance) begin
        baseAddr <= addr;
        burstCnt <= '0;
        lastCmd  <= capCmd;
      end else begin
        burstCnt <= nextCnt;
      end
      s1Cmd    <= capCmd;
      s1Addr   <= capAddr;
      s1ByteWe <= ~byteWeN;
      s2Cmd    <= s1Cmd;
      s2Addr   <= s1Addr;
      s2ByteWe <= s1ByteWe;
    end
  end

  always_comb begin
    strb.pipeEn  = !clkEnN;
    strb.s2Write = (s2Cmd == CMD_WRITE);
    strb.s2Read  = (s2Cmd == CMD_READ);
    strb.fwdHit  = (s1Cmd == CMD_READ) && (s2Cmd == CMD_WRITE) && (s1Addr == s2Addr);
  end

endmodule

// File: rtl/sram_nowait_data.sv
module sram_nowait_data
  import sram_nowait_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [ADDR_W-1:0]       s1Addr,
  input  logic [ADDR_W-1:0]       s2Addr,
  input  logic [BYTES-1:0]        s2ByteWe,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  output logic [BYTES*BYTE_W-1:0] dataOut,
  output logic                    dataOutEn
);

  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] arrWord;
  logic [DATA_W-1:0] fwdWord;
  logic [DATA_W-1:0] rdReg;

  // array write in the write data phase, lane by lane
  always_ff @(posedge clk) begin
    if (strb.pipeEn && strb.s2Write) begin
      for (int b = 0; b < BYTES; b++) begin
        if (s2ByteWe[b]) mem[s2Addr][b*BYTE_W +: BYTE_W] <= dataIn[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign arrWord = mem[s1Addr];

  // per-lane bypass of a write committing on the same edge
  for (genvar g = 0; g < BYTES; g++) begin : gLane
    assign fwdWord[g*BYTE_W +: BYTE_W] = (strb.fwdHit && s2ByteWe[g])
                                         ? dataIn[g*BYTE_W +: BYTE_W]
                                         : arrWord[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReg     <= '0;
      dataOut   <= '0;
      dataOutEn <= 1'b0;
    end else if (strb.pipeEn) begin
      rdReg     <= fwdWord;
      dataOutEn <= strb.s2Read;
      if (strb.s2Read) dataOut <= rdReg;
    end
  end

endmodule

// File: rtl/sram_nowait.sv
module sram_nowait
  import sram_nowait_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    advance,
  input  logic                    rwN,
  input  logic                    chipEn1N,
  input  logic                    chipEn2,
  input  logic                    chipEn3N,
  input  logic                    burstMode,
  input  logic [BYTES-1:0]        byteWeN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  output logic [BYTES*BYTE_W-1:0] dataOut,
  output logic                    dataOutEn
);

  strobe_t           strb;
  logic [ADDR_W-1:0] s1Addr;
  logic [ADDR_W-1:0] s2Addr;
  logic [BYTES-1:0]  s2ByteWe;

  sram_nowait_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advance(advance), .rwN(rwN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .burstMode(burstMode), .byteWeN(byteWeN), .addr(addr),
    .strb(strb), .s1Addr(s1Addr), .s2Addr(s2Addr), .s2ByteWe(s2ByteWe)
  );

  sram_nowait_data #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .s1Addr(s1Addr), .s2Addr(s2Addr),
    .s2ByteWe(s2ByteWe), .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

endmodule

// File: rtl/sram_nowait_chk.sv
module sram_nowait_chk #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    clkEnN,
  input logic                    advance,
  input logic                    rwN,
  input logic                    chipEn1N,
  input logic                    chipEn2,
  input logic                    chipEn3N,
  input logic [ADDR_W-1:0]       addr,
  input logic [BYTES*BYTE_W-1:0] dataOut,
  input logic                    dataOutEn
);

  logic sel;
  assign sel = !chipEn1N && chipEn2 && !chipEn3N;

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!dataOutEn && (dataOut == '0));
    end
  end

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advance && sel && rwN) ##1 !clkEnN ##1 !clkEnN |=> dataOutEn);

  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advance && !sel) ##1 (!clkEnN && !advance) ##1 !clkEnN |=> !dataOutEn);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(dataOut) && $stable(dataOutEn)));

  assert_write_phase_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advance && sel && !rwN) ##1 (!clkEnN && !advance) ##1 !clkEnN |=> !dataOutEn);

  logic unusedAddr;
  assign unusedAddr = ^addr;

endmodule

bind sram_nowait sram_nowait_chk #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advance(advance), .rwN(rwN),
  .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N), .addr(addr),
  .dataOut(dataOut), .dataOutEn(dataOutEn)
);

// File: tb/sram_nowait_tb.sv
module sram_nowait_tb;
  localparam int AW = 4;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clkEnN = 1'b1;
  logic          advance = 1'b0;
  logic          rwN = 1'b1;
  logic          chipEn1N = 1'b1;
  logic          chipEn2 = 1'b0;
  logic          chipEn3N = 1'b1;
  logic          burstMode = 1'b0;
  logic [NB-1:0] byteWeN = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataOutEn;

  always #10 clk = ~clk;

  sram_nowait #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .advance(advance), .rwN(rwN),
    .chipEn1N(chipEn1N), .chipEn2(chipEn2), .chipEn3N(chipEn3N),
    .burstMode(burstMode), .byteWeN(byteWeN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  typedef struct {
    bit          isRead;
    logic [DW-1:0] data;
    string       tag;
  } item_t;

  item_t         q[$];
  logic [DW-1:0] model [DEPTH];
  int            ringCmd [4];
  int            ringAddr [4];
  logic [NB-1:0] ringBe [4];
  string         ringTag [4];
  int            step = 0;
  bit            bMode = 1'b0;
  int            bBase = 0;
  int            bCnt = 0;
  int            bCmd = 0;
  string         curTag = "R2";
  int            checks = 0;
  int            failures = 0;
  logic [DW-1:0] lastOut = '0;
  logic          lastOe = 1'b0;
  bit            monEn;
  bit            done = 1'b0;

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one enabled cycle: cmd 0 idle, 1 read, 2 write; ceBad bits mark inactive enables
  task automatic drive(bit adv, bit rw, bit [2:0] ceBad, logic [NB-1:0] beN, int a);
    int oldS, prevS, low, eff;
    logic [DW-1:0] wd;
    item_t it;
    @(negedge clk);
    oldS  = (step + 2) & 3;
    prevS = (step + 3) & 3;
    wd = DW'({$urandom(), $urandom()});
    if (ringCmd[oldS] == 2) begin
      for (int b = 0; b < NB; b++)
        if (ringBe[oldS][b]) model[ringAddr[oldS]][b*BW +: BW] = wd[b*BW +: BW];
    end
    it.isRead = (ringCmd[prevS] == 1);
    it.data   = model[ringAddr[prevS]];
    it.tag    = it.isRead ? ringTag[prevS] : (ringCmd[prevS] == 2 ? "R10" : "R4");
    q.push_back(it);
    if (!adv) begin
      bBase = a; bCnt = 0;
      bCmd  = (ceBad != 0) ? 0 : (rw ? 1 : 2);
      eff   = a;
    end else begin
      bCnt = (bCnt + 1) & 3;
      low  = bMode ? ((bBase & 3) ^ bCnt) : (((bBase & 3) + bCnt) & 3);
      eff  = (bBase & ~3) | low;
    end
    ringCmd[step & 3]  = bCmd;
    ringAddr[step & 3] = eff;
    ringBe[step & 3]   = ~beN;
    ringTag[step & 3]  = curTag;
    clkEnN   = 1'b0;
    advance  = adv;
    rwN      = rw;
    chipEn1N = ceBad[0];
    chipEn2  = !ceBad[1];
    chipEn3N = ceBad[2];
    byteWeN  = beN;
    addr     = AW'(a);
    dataIn   = wd;
    burstMode = bMode;
    step++;
  endtask

  task automatic stall();
    @(negedge clk);
    clkEnN   = 1'b1;
    advance  = 1'($urandom());
    rwN      = 1'($urandom());
    chipEn1N = 1'($urandom());
    chipEn2  = 1'($urandom());
    chipEn3N = 1'($urandom());
    byteWeN  = NB'($urandom());
    addr     = AW'($urandom());
    dataIn   = DW'({$urandom(), $urandom()});
    burstMode = 1'($urandom());
  endtask

  // monitor: one expected item per enabled edge
  always @(posedge clk) begin
    item_t it;
    monEn = rstN && !clkEnN;
    #5;
    if (rstN && !done) begin
      if (monEn) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 queue empty", '0, '0);
        end else begin
          it = q.pop_front();
          chk(dataOutEn == it.isRead, it.tag, DW'(dataOutEn), DW'(it.isRead));
          if (it.isRead) chk(dataOut === it.data, it.tag, dataOut, it.data);
        end
      end else begin
        chk(dataOut === lastOut && dataOutEn === lastOe, "R8", dataOut, lastOut);
      end
      lastOut = dataOut;
      lastOe  = dataOutEn;
    end
  end

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    item_t first;
    for (int i = 0; i < 4; i++) begin ringCmd[i] = 0; ringAddr[i] = 0; ringBe[i] = '0; ringTag[i] = "R4"; end
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #5;
    chk(dataOut == '0, "R1", dataOut, '0);
    chk(dataOutEn == 1'b0, "R1", DW'(dataOutEn), '0);
    @(negedge clk);
    first.isRead = 1'b0; first.data = '0; first.tag = "R1";
    q.push_back(first);
    rstN = 1'b1;

    // R2: full preload then readback
    curTag = "R2";
    for (int a = 0; a < DEPTH; a++) drive(1'b0, 1'b0, 3'b000, '0, a);
    for (int a = 0; a < DEPTH; a++) drive(1'b0, 1'b1, 3'b000, '1, a);

    // R3: lane masks
    curTag = "R3";
    drive(1'b0, 1'b0, 3'b000, 4'b1010, 3);
    drive(1'b0, 1'b0, 3'b000, 4'b0111, 4);
    drive(1'b0, 1'b0, 3'b000, 4'b1111, 5);
    drive(1'b0, 1'b0, 3'b000, 4'b1110, 6);
    for (int a = 3; a < 7; a++) drive(1'b0, 1'b1, 3'b000, '1, a);

    // R4: each chip enable inactive, then advance after deselect
    curTag = "R4";
    drive(1'b0, 1'b0, 3'b001, '0, 5);
    drive(1'b1, 1'b0, 3'b000, '0, 0);
    drive(1'b0, 1'b0, 3'b010, '0, 6);
    drive(1'b1, 1'b1, 3'b000, '0, 0);
    drive(1'b0, 1'b1, 3'b100, '0, 7);
    drive(1'b1, 1'b1, 3'b000, '0, 0);
    for (int a = 4; a < 8; a++) drive(1'b0, 1'b1, 3'b000, '1, a);

    // R5: burst keeps command despite rwN and enables on advance
    curTag = "R5"; bMode = 1'b0;
    drive(1'b0, 1'b0, 3'b000, '0, 8);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 3'b111, '0, 0);
    drive(1'b0, 1'b1, 3'b000, '1, 9);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 3'b111, '0, 0);

    // R6: wrap-around order
    curTag = "R6"; bMode = 1'b0;
    drive(1'b0, 1'b0, 3'b000, '0, 6);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 3'b000, '0, 0);
    drive(1'b0, 1'b1, 3'b000, '1, 5);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 3'b000, '1, 0);

    // R7: XOR order
    curTag = "R7"; bMode = 1'b1;
    drive(1'b0, 1'b0, 3'b000, '0, 13);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 3'b000, '0, 0);
    drive(1'b0, 1'b1, 3'b000, '1, 14);
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b1, 3'b000, '1, 0);
    drive(1'b0, 1'b1, 3'b000, '1, 13);
    drive(1'b0, 1'b1, 3'b000, '1, 12);

    // R9: read right behind write, partial merge, alternation, random mix
    curTag = "R9"; bMode = 1'b0;
    drive(1'b0, 1'b0, 3'b000, '0, 2);
    drive(1'b0, 1'b1, 3'b000, '1, 2);
    drive(1'b0, 1'b0, 3'b000, 4'b0110, 2);
    drive(1'b0, 1'b1, 3'b000, '1, 2);
    for (int i = 0; i < 6; i++) drive(1'b0, i[0], 3'b000, NB'($urandom()), 11);
    for (int i = 0; i < 300; i++) begin
      bit adv;
      adv = ($urandom() % 4) == 0;
      if (!adv) bMode = 1'($urandom());
      drive(adv, 1'($urandom()), ($urandom() % 8 == 0) ? 3'($urandom()) : 3'b000,
            NB'($urandom()), int'($urandom() % DEPTH));
    end

    // R8: stalls mixed into traffic and bursts
    curTag = "R8";
    for (int i = 0; i < 120; i++) begin
      if ($urandom() % 3 == 0) stall();
      else begin
        bit adv;
        adv = ($urandom() % 3) == 0;
        if (!adv) bMode = 1'($urandom());
        drive(adv, 1'($urandom()), 3'b000, NB'($urandom()), int'($urandom() % DEPTH));
      end
    end

    curTag = "R2";
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 3'b111, '1, 0);
    @(posedge clk);
    #6;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule